// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel with a small byte-wide register port for a CPU. Software first writes a control byte. The control byte chooses one of four output behaviours, binary or decimal (BCD) counting, and how the count is moved across the 8-bit bus: low byte only, high byte only, or both bytes with the low byte first. Software then writes the starting count. The channel counts falling edges of its own count clock while the gate input is high. The output waveform depends on the mode. Software can read the running count at any time.

All logic runs on one system clock. The count clock and the gate are brought through a synchroniser, and a falling edge of the synchronised count clock becomes a one-cycle tick. Bus strobes are sampled on the system clock. A write acts once, on the first cycle in which select and write are both high. A read returns data while select and read are high, and the byte order for reads moves on when the read ends. Several channels can share one bus. Each instance is given its own channel number, from 0 to 2. Address 3 is shared by all channels and carries control bytes, which name the channel they are meant for.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low, the count reads 0 and reads return the low byte. Count writes are ignored until a control byte has been accepted.
- R2: A write is acted on only while select is high. A write to address 3 is a control byte. A write to the channel's own address is a count byte, and writes to any other counter address are ignored. A control byte is ignored when its bits [7:6] differ from the channel number, when its access field is 00, or when its mode field is 1, 5, 6 or 7.
- R3: Control byte fields: bits [5:4] set access (01 low byte, 10 high byte, 11 both), bits [3:1] set the mode (0 terminal-count flag, 2 rate generator, 3 square wave, 4 software strobe), and bit 0 selects BCD. An accepted control byte stops the counting, forces the output low for mode 0 and high for the other modes, and resets the byte order for reads and writes.
- R4: With both-byte access, the first count byte written is the low byte and the second is the high byte. The count takes effect only after the second byte. With single-byte access, the byte that is not written becomes zero.
- R5: On the first count-clock falling edge after a complete count write, the counter loads the value N. On each later falling edge it counts down by one. An N of 0 acts as 65536 (binary) or 10000 (BCD). A new count written while the channel runs takes effect at the next falling edge.
- R6: While the gate is low, count-clock edges after the load leave the count unchanged.
- R7: In BCD mode each 4-bit digit borrows decimally (0x10 is followed by 0x09), and 0000 is followed by 9999. Loaded values must be valid BCD.
- R8: In mode 0 the output is low from the count write and goes high when the count reaches zero. It then stays high while the counter wraps, until a new count or control byte arrives.
- R9: In mode 2 the output is low for one count-clock period while the count is 1. The counter then reloads N, so the period is N count-clock periods (N ≥ 2).
- R10: In mode 3 the output is high for ceil(N/2) and low for floor(N/2) count-clock periods, repeating (N ≥ 3 for odd N, N ≥ 2 for even N).
- R11: In mode 4 the output goes low for exactly one count-clock period when the count reaches zero, only once for each count loaded, and is high otherwise.
- R12: A read at the channel's address returns the running count. With low or high access it returns that byte. With both-byte access it returns the low byte and then the high byte on successive reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address; 3 is the control byte |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; zero when this channel is not being read |
| cnt_clk | input | 1 | Count clock; falling edges count |
| cnt_gate | input | 1 | Count enable, active high |
| tmr_out | output | 1 | Timer output waveform |

## Verification
Embedded properties watch, on every cycle, the rules that tie state together: the tick lasts a single cycle, a low gate freezes the count, mode 0 raises its output only at a zero count, mode 2 is low only while the count is 1, square-wave toggles happen only at a reload, an accepted control byte resets the byte order, and control bytes for other channels leave the configuration alone. The waveform periods, the odd and even square-wave splits, the decimal borrow and the 9999 wrap, the byte sequences seen from the bus, and the rejection of foreign or unsupported writes can only be shown by the directed scenarios, which drive count-clock pulses and compare the output and the read-back count against values worked out from the requirements.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Operating behaviours selectable through the control byte
   typedef enum logic [2:0] {
      MODE_TC     = 3'd0,
      MODE_RATE   = 3'd2,
      MODE_SQUARE = 3'd3,
      MODE_STROBE = 3'd4
   } pit_mode_e;

   // How a count crosses the byte-wide bus
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_BOTH = 2'd3
   } pit_acc_e;

   localparam logic [1:0] ADDR_CTRL = 2'd3;

   function automatic logic mode_supported(input logic [2:0] m);
      return (m == 3'd0) || (m == 3'd2) || (m == 3'd3) || (m == 3'd4);
   endfunction

endpackage

// File: rtl/pit_sync.sv
module pit_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pit_bus_if.sv
module pit_bus_if
   import pit_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CHAN_ID = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                rd,
   input  logic                wr,
   input  logic [1:0]          addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [2*DATA_W-1:0] cnt,
   output pit_mode_e           mode,
   output logic                bcd,
   output pit_mode_e           new_mode,
   output logic                cfg_wr,
   output logic                load_req,
   output logic [2*DATA_W-1:0] reload
);

   localparam int         CNT_W    = 2 * DATA_W;
   localparam logic [1:0] CHAN_SEL = 2'(CHAN_ID);

   logic              wr_q, rd_q, wr_evt, rd_act, rd_end;
   logic              data_hit, configured, wr_hi, rd_hi;
   pit_acc_e          acc;
   pit_mode_e         mode_q;
   logic              bcd_q;
   logic [DATA_W-1:0] lo_stage;
   logic [CNT_W-1:0]  reload_q;

   assign wr_evt   = sel & wr & ~wr_q;
   assign rd_act   = sel & rd & (addr == CHAN_SEL);
   assign rd_end   = rd_q & ~rd_act;
   assign cfg_wr   = wr_evt && (addr == ADDR_CTRL) && (wdata[7:6] == CHAN_SEL) &&
                     (wdata[5:4] != 2'b00) && mode_supported(wdata[3:1]);
   assign data_hit = wr_evt && (addr == CHAN_SEL) && configured;
   assign load_req = data_hit && ((acc != ACC_BOTH) || wr_hi);
   assign new_mode = pit_mode_e'(wdata[3:1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q       <= 1'b0;
         rd_q       <= 1'b0;
         acc        <= ACC_LO;
         mode_q     <= MODE_TC;
         bcd_q      <= 1'b0;
         configured <= 1'b0;
         wr_hi      <= 1'b0;
         rd_hi      <= 1'b0;
         lo_stage   <= '0;
         reload_q   <= '0;
      end else begin
         wr_q <= sel & wr;
         rd_q <= rd_act;
         if (cfg_wr) begin
            acc        <= pit_acc_e'(wdata[5:4]);
            mode_q     <= new_mode;
            bcd_q      <= wdata[0];
            configured <= 1'b1;
            wr_hi      <= 1'b0;
            rd_hi      <= 1'b0;
         end else begin
            if (data_hit) begin
               unique case (acc)
                  ACC_LO: reload_q <= {{DATA_W{1'b0}}, wdata};
                  ACC_HI: reload_q <= {wdata, {DATA_W{1'b0}}};
                  default: begin
                     if (!wr_hi) begin
                        lo_stage <= wdata;
                        wr_hi    <= 1'b1;
                     end else begin
                        reload_q <= {wdata, lo_stage};
                        wr_hi    <= 1'b0;
                     end
                  end
               endcase
            end
            if (rd_end && (acc == ACC_BOTH)) rd_hi <= ~rd_hi;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_act) begin
         unique case (acc)
            ACC_HI:   rdata = cnt[CNT_W-1:DATA_W];
            ACC_BOTH: rdata = rd_hi ? cnt[CNT_W-1:DATA_W] : cnt[DATA_W-1:0];
            default:  rdata = cnt[DATA_W-1:0];
         endcase
      end
   end

   assign mode   = mode_q;
   assign bcd    = bcd_q;
   assign reload = reload_q;

   // R4: an accepted control byte restarts both byte sequences at the low byte
   assert_order_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!wr_hi && !rd_hi));

   // R2: control bytes naming another channel leave the configuration untouched
   assert_foreign_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && (addr == ADDR_CTRL) && (wdata[7:6] != CHAN_SEL))
      |=> ($stable(acc) && $stable(mode_q) && $stable(bcd_q)));

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             cfg_wr,
   input  pit_mode_e        new_mode,
   input  pit_mode_e        mode,
   input  logic             bcd,
   input  logic             load_req,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             out
);

   localparam int NDIG = CNT_W / 4;

   logic [CNT_W-1:0] cnt_q, dec_bin, dec_bcd, dec;
   logic             out_q, armed, pend, fired;
   logic [1:0]       amt;
   logic             dec_zero, dec_one;

   // Step size: square wave moves two per edge, with one odd step per phase
   always_comb begin
      amt = 2'd1;
      if (mode == MODE_SQUARE) begin
         if (cnt_q[0]) amt = out_q ? 2'd1 : 2'd3;
         else          amt = 2'd2;
      end
   end

   assign dec_bin = cnt_q - CNT_W'(amt);

   generate
      if (BCD_EN) begin : g_bcd
         always_comb begin : bcd_sub
            logic [1:0] sub;
            logic [4:0] dg;
            dec_bcd = '0;
            sub     = amt;
            for (int i = 0; i < NDIG; i++) begin
               dg = {1'b0, cnt_q[4*i +: 4]};
               if (dg >= {3'b000, sub}) begin
                  dec_bcd[4*i +: 4] = 4'(dg - {3'b000, sub});
                  sub = 2'd0;
               end else begin
                  dec_bcd[4*i +: 4] = 4'(dg + 5'd10 - {3'b000, sub});
                  sub = 2'd1;
               end
            end
         end
         assign dec = bcd ? dec_bcd : dec_bin;
      end else begin : g_bin
         assign dec_bcd = dec_bin;
         assign dec     = dec_bin;
      end
   endgenerate

   assign dec_zero = (dec == '0);
   assign dec_one  = (dec == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
         armed <= 1'b0;
         pend  <= 1'b0;
         fired <= 1'b0;
      end else if (cfg_wr) begin
         armed <= 1'b0;
         pend  <= 1'b0;
         fired <= 1'b0;
         out_q <= (new_mode != MODE_TC);
      end else begin
         pend <= load_req | (pend & ~tick);
         if (load_req && (mode == MODE_TC)) out_q <= 1'b0;
         if (tick && pend) begin
            cnt_q <= reload;
            armed <= 1'b1;
            fired <= 1'b0;
            out_q <= (mode != MODE_TC);
         end else if (tick && armed && gate) begin
            unique case (mode)
               MODE_TC: begin
                  cnt_q <= dec;
                  if (dec_zero) out_q <= 1'b1;
               end
               MODE_RATE: begin
                  if (dec_zero) begin
                     cnt_q <= reload;
                     out_q <= 1'b1;
                  end else begin
                     cnt_q <= dec;
                     out_q <= !dec_one;
                  end
               end
               MODE_SQUARE: begin
                  if (dec_zero) begin
                     cnt_q <= reload;
                     out_q <= ~out_q;
                  end else begin
                     cnt_q <= dec;
                  end
               end
               default: begin
                  cnt_q <= dec;
                  if (dec_zero && !fired) begin
                     out_q <= 1'b0;
                     fired <= 1'b1;
                  end else begin
                     out_q <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign cnt = cnt_q;
   assign out = out_q;

   // R6: with the gate low, a count-clock edge after the load moves nothing
   assert_gate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !gate && !pend && !cfg_wr) |=> $stable(cnt_q));

   // R8: the terminal-count flag rises only with a zero count
   assert_tc_rise_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_q) && (mode == MODE_TC)) |-> (cnt_q == '0));

   // R9: the rate generator output is low only while the count is one
   assert_rate_low_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_RATE) && armed && !out_q) |-> (cnt_q == CNT_W'(1)));

   // R10: a square-wave phase change coincides with a reload
   assert_square_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_SQUARE) && armed && $past(armed) && !$past(load_req) &&
       (out_q != $past(out_q))) |-> (cnt_q == reload));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CHAN_ID     = 0,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit BCD_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cnt_clk,
   input  logic              cnt_gate,
   output logic              tmr_out
);

   localparam int CNT_W = 2 * DATA_W;

   initial begin
      assert (DATA_W >= 8 && (DATA_W % 4) == 0)
         else $error("DATA_W must be at least 8 and a multiple of 4");
      assert (CHAN_ID >= 0 && CHAN_ID <= 2)
         else $error("CHAN_ID must be 0, 1 or 2");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]       sync_q;
   logic             cclk_prev, tick;
   pit_mode_e        mode, new_mode;
   logic             bcd, cfg_wr, load_req;
   logic [CNT_W-1:0] reload, cnt;

   pit_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cnt_gate, cnt_clk}),
      .q     (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cclk_prev <= 1'b0;
      else        cclk_prev <= sync_q[0];
   end

   assign tick = cclk_prev & ~sync_q[0];

   pit_bus_if #(
      .DATA_W  (DATA_W),
      .CHAN_ID (CHAN_ID)
   ) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bus_sel),
      .rd       (bus_rd),
      .wr       (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .cnt      (cnt),
      .mode     (mode),
      .bcd      (bcd),
      .new_mode (new_mode),
      .cfg_wr   (cfg_wr),
      .load_req (load_req),
      .reload   (reload)
   );

   pit_count_core #(
      .CNT_W  (CNT_W),
      .BCD_EN (BCD_EN)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .gate     (sync_q[1]),
      .cfg_wr   (cfg_wr),
      .new_mode (new_mode),
      .mode     (mode),
      .bcd      (bcd),
      .load_req (load_req),
      .reload   (reload),
      .cnt      (cnt),
      .out      (tmr_out)
   );

   // R5: each count-clock falling edge yields a single-cycle tick
   assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_CCLK  = 8;
   localparam int WDOG       = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       cnt_clk = 1'b1;
   logic       cnt_gate = 1'b1;
   logic       tmr_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pit_channel u_pit_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt_clk   (cnt_clk),
      .cnt_gate  (cnt_gate),
      .tmr_out   (tmr_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic s = 1'b1);
      @(negedge clk);
      bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [1:0] a, output int v);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      v = int'(bus_rdata);
      bus_sel = 1'b0; bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd16(output int v);
      int lo, hi;
      bus_read(2'd0, lo);
      bus_read(2'd0, hi);
      v = (hi << 8) | lo;
   endtask

   task automatic cpulse(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cnt_clk = 1'b0;
         repeat (HALF_CCLK) @(negedge clk);
         cnt_clk = 1'b1;
         repeat (HALF_CCLK) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      int v;
      chk("R1 out after reset", int'(tmr_out), 0);
      bus_read(2'd0, v);
      chk("R1 count after reset", v, 0);
      bus_write(2'd0, 8'h05);
      cpulse(2);
      bus_read(2'd0, v);
      chk("R1 count write before control ignored", v, 0);
      chk("R1 out stays low", int'(tmr_out), 0);
   endtask

   task automatic t_mode0;
      int v;
      bus_write(2'd3, 8'h30);
      chk("R3 mode0 out low after control", int'(tmr_out), 0);
      bus_write(2'd0, 8'h05);
      cpulse(2);
      rd16(v);
      chk("R4 half-written count not loaded", v, 0);
      bus_write(2'd0, 8'h00);
      cpulse(1);
      rd16(v);
      chk("R5 load on first edge", v, 5);
      cpulse(4);
      chk("R8 out low before zero", int'(tmr_out), 0);
      rd16(v);
      chk("R12 running count read", v, 1);
      cpulse(1);
      chk("R8 out high at zero", int'(tmr_out), 1);
      rd16(v);
      chk("R5 count reached zero", v, 0);
      cpulse(1);
      rd16(v);
      chk("R5 binary wrap", v, 16'hFFFF);
      chk("R8 out stays high after wrap", int'(tmr_out), 1);
   endtask

   task automatic t_gate;
      int v;
      bus_write(2'd3, 8'h30);
      cpulse(2);
      rd16(v);
      chk("R3 control byte halts counting", v, 16'hFFFF);
      chk("R3 out low after mode0 control", int'(tmr_out), 0);
      bus_write(2'd0, 8'h03);
      bus_write(2'd0, 8'h00);
      cpulse(1);
      cnt_gate = 1'b0;
      repeat (4) @(negedge clk);
      cpulse(5);
      rd16(v);
      chk("R6 gate low holds count", v, 3);
      chk("R6 out unchanged while gated", int'(tmr_out), 0);
      cnt_gate = 1'b1;
      repeat (4) @(negedge clk);
      cpulse(2);
      chk("R8 out low at count 1", int'(tmr_out), 0);
      cpulse(1);
      chk("R8 out high after gate reopened", int'(tmr_out), 1);
   endtask

   task automatic t_rate;
      bus_write(2'd3, 8'h14);
      chk("R3 rate out high after control", int'(tmr_out), 1);
      bus_write(2'd0, 8'h04);
      cpulse(1);
      chk("R9 out high after load", int'(tmr_out), 1);
      for (int p = 1; p <= 8; p++) begin
         cpulse(1);
         chk("R9 rate waveform", int'(tmr_out), (p % 4 == 3) ? 0 : 1);
      end
   endtask

   task automatic t_square;
      bus_write(2'd3, 8'h36);
      chk("R3 square out high after control", int'(tmr_out), 1);
      bus_write(2'd0, 8'h05);
      bus_write(2'd0, 8'h00);
      cpulse(1);
      chk("R10 odd load out high", int'(tmr_out), 1);
      for (int p = 1; p <= 10; p++) begin
         cpulse(1);
         chk("R10 odd square waveform", int'(tmr_out), (p % 5 < 3) ? 1 : 0);
      end
      bus_write(2'd3, 8'h36);
      bus_write(2'd0, 8'h04);
      bus_write(2'd0, 8'h00);
      cpulse(1);
      for (int p = 1; p <= 8; p++) begin
         cpulse(1);
         chk("R10 even square waveform", int'(tmr_out), (p % 4 < 2) ? 1 : 0);
      end
   endtask

   task automatic t_strobe_bcd;
      int v;
      bus_write(2'd3, 8'h19);
      chk("R3 strobe out high after control", int'(tmr_out), 1);
      bus_write(2'd0, 8'h12);
      cpulse(1);
      bus_read(2'd0, v);
      chk("R12 low-byte read after load", v, 8'h12);
      cpulse(3);
      bus_read(2'd0, v);
      chk("R7 decimal borrow", v, 8'h09);
      cpulse(8);
      chk("R11 out high before zero", int'(tmr_out), 1);
      cpulse(1);
      chk("R11 strobe low at zero", int'(tmr_out), 0);
      bus_read(2'd0, v);
      chk("R7 count at zero", v, 8'h00);
      cpulse(1);
      chk("R11 strobe lasts one period", int'(tmr_out), 1);
      bus_read(2'd0, v);
      chk("R7 wrap to 9999", v, 8'h99);
      for (int p = 0; p < 6; p++) begin
         cpulse(1);
         chk("R11 no second strobe", int'(tmr_out), 1);
      end
   endtask

   task automatic t_high_only;
      int v;
      bus_write(2'd3, 8'h20);
      bus_write(2'd0, 8'h12);
      cpulse(1);
      bus_read(2'd0, v);
      chk("R4 high-only load", v, 8'h12);
      cpulse(1);
      bus_read(2'd0, v);
      chk("R12 high byte after borrow", v, 8'h11);
   endtask

   task automatic t_ignore;
      int v;
      bus_write(2'd3, 8'h70);
      bus_write(2'd3, 8'h32);
      bus_write(2'd3, 8'h00);
      bus_write(2'd1, 8'h55);
      bus_write(2'd0, 8'h77, 1'b0);
      chk("R2 out unchanged by ignored writes", int'(tmr_out), 0);
      cpulse(1);
      bus_read(2'd0, v);
      chk("R2 ignored writes leave config and count", v, 8'h11);
      chk("R2 out still low", int'(tmr_out), 0);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_mode0();
      t_gate();
      t_rate();
      t_square();
      t_strobe_bcd();
      t_high_only();
      t_ignore();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule